// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block holds the single-root I/O virtualisation capability structure of a physical function. The structure sits in extended configuration space. A configuration access port with a dword address, write data, byte enables, a write strobe and a read strobe reaches it. Reads are registered, and the data appears on the cycle after the read strobe.

The block keeps the fixed hardware limits as parameters and the software-writable control fields as flops. It applies the legality rules that link the fields:

- The VF count is frozen while VFs are enabled.
- The VF count can never exceed the hardware maximum.
- The system page size must be a single supported size.
- Migration enable follows the migration capability bit.

The live values go out to the rest of the function. A readiness flag rises a parameterised number of cycles after VFs are enabled, and it drops at once when they are disabled.

Top module: `sriov_cap_regs`

## Requirements
- R1: A read of the structure's first dword returns {NEXT_PTR[31:20], CAP_VER[19:16], 16'h0010}. Read data appears on `rdata_o` one cycle after `rd_i` and holds until the next read. A read of a dword outside the nine dwords of the structure returns 0.
- R2: The read-only dwords read back their parameter values, and writes to them have no effect:
  - +04h: MIG_MSG in [31:21] and MIG_CAP in bit 0.
  - +0Ch: TOTAL_VFS in [31:16] and INITIAL_VFS in [15:0].
  - +14h: VF_STRIDE in [31:16] and FIRST_OFS in [15:0].
  - +18h: VF_DEVID in [31:16].
  - +1Ch: SUP_PAGES.
- R3: The control dword at +08h holds five fields, and all other bits read 0:
  - bit 0: VF enable
  - bit 1: migration enable
  - bit 2: migration interrupt enable
  - bit 3: VF memory space enable
  - bit 4: ARI hierarchy
  Each field is driven on its own output port from the cycle after the write.
- R4: A write to the VF count (+10h bits [31:16]) is ignored while VF enable is 1. The VF count output is stable on every cycle in which VF enable is 1.
- R5: A VF count write whose value exceeds TOTAL_VFS is ignored and the old value is kept.
- R6: A system page size write (+20h) is accepted only if the value has exactly one bit set and that bit is also set in SUP_PAGES. Bit 0 means 4 KB, and each higher bit doubles the size. Any other value is ignored.
- R7: When MIG_CAP is 0, the migration enable bit can never be set.
- R8: Only bytes whose byte enable is 1 are written. The legality checks of R4 to R6 apply to the merged value.
- R9: `vf_ready_o` rises exactly READY_DLY cycles after the cycle in which `vf_en_o` rises.
- R10: `vf_ready_o` drops in the same cycle that `vf_en_o` falls. A later re-enable restarts the full delay.
- R11: After reset, all control bits are 0, the VF count is 0, the system page size is 1 (4 KB) and `vf_ready_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 10 | Dword address in extended configuration space |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| vf_en_o | output | 1 | VF enable |
| mig_en_o | output | 1 | Migration enable |
| mig_int_en_o | output | 1 | Migration interrupt enable |
| vf_mse_o | output | 1 | VF memory space enable |
| ari_hier_o | output | 1 | ARI hierarchy |
| num_vfs_o | output | 16 | Active VF count |
| first_ofs_o | output | 16 | Routing ID offset to the first VF |
| stride_o | output | 16 | Routing ID step between VFs |
| sys_page_o | output | 32 | Selected system page size mask |
| vf_ready_o | output | 1 | VFs ready after the enable delay |

## Verification
The assertions check the following invariants on every cycle:
- the VF count stays frozen while VFs are enabled;
- the VF count never exceeds its maximum;
- the page size stays a single supported bit;
- migration enable stays clear without the capability;
- the readiness flag never rises without VF enable having been on in the previous cycle;
- the header ID appears after a header read.

Only the directed scenarios show the following:
- the exact cycle count of the readiness delay and its restart;
- the treatment of partial byte writes;
- that writes to read-only dwords leave their values intact;
- that illegal writes keep the old value rather than some other legal one.

// File: rtl/sriov_cap_pkg.sv
package sriov_cap_pkg;
  localparam logic [15:0] CAP_ID = 16'h0010;

  localparam logic [3:0] W_HDR  = 4'd0;
  localparam logic [3:0] W_CAP  = 4'd1;
  localparam logic [3:0] W_CTRL = 4'd2;
  localparam logic [3:0] W_VFLM = 4'd3;
  localparam logic [3:0] W_NUM  = 4'd4;
  localparam logic [3:0] W_RID  = 4'd5;
  localparam logic [3:0] W_DEV  = 4'd6;
  localparam logic [3:0] W_SUP  = 4'd7;
  localparam logic [3:0] W_PAGE = 4'd8;

  // bit order matches the control dword, vf_en at bit 0
  typedef struct packed {
    logic ari;
    logic mse;
    logic mig_int_en;
    logic mig_en;
    logic vf_en;
  } ctrl_t;
endpackage

// File: rtl/sriov_ctrl_regs.sv
module sriov_ctrl_regs
  import sriov_cap_pkg::*;
#(
  parameter logic [15:0] TOTAL_VFS = 16'd64,
  parameter logic [31:0] SUP_PAGES = 32'h0000_0553,
  parameter bit          MIG_CAP   = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [3:0]  idx_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output ctrl_t       ctrl_o,
  output logic [15:0] num_vfs_o,
  output logic [31:0] sys_page_o
);
  ctrl_t       ctrl_q;
  logic [15:0] num_q, num_cand;
  logic [31:0] page_q, page_cand;
  logic        num_ok, page_ok;

  always_comb begin
    num_cand[7:0]  = be_i[2] ? wdata_i[23:16] : num_q[7:0];
    num_cand[15:8] = be_i[3] ? wdata_i[31:24] : num_q[15:8];
    num_ok = (be_i[2] | be_i[3]) && !ctrl_q.vf_en && (num_cand <= TOTAL_VFS);
  end

  always_comb begin
    for (int b = 0; b < 4; b++)
      page_cand[8*b +: 8] = be_i[b] ? wdata_i[8*b +: 8] : page_q[8*b +: 8];
    page_ok = (|be_i) && $onehot(page_cand) && ((page_cand & SUP_PAGES) != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      num_q  <= '0;
      page_q <= 32'h1;
    end else if (wr_i) begin
      if (idx_i == W_CTRL && be_i[0]) begin
        ctrl_q.vf_en      <= wdata_i[0];
        ctrl_q.mig_en     <= wdata_i[1] & MIG_CAP;
        ctrl_q.mig_int_en <= wdata_i[2];
        ctrl_q.mse        <= wdata_i[3];
        ctrl_q.ari        <= wdata_i[4];
      end
      if (idx_i == W_NUM && num_ok) num_q <= num_cand;
      if (idx_i == W_PAGE && page_ok) page_q <= page_cand;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign num_vfs_o  = num_q;
  assign sys_page_o = page_q;

  assert_numvf_locked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.vf_en |=> $stable(num_q));
  assert_numvf_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    num_q <= TOTAL_VFS);
  assert_page_legal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(page_q) && ((page_q & SUP_PAGES) != '0));
  assert_mig_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !MIG_CAP |-> !ctrl_q.mig_en);
endmodule

// File: rtl/sriov_ready_timer.sv
module sriov_ready_timer #(
  parameter int READY_DLY = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ready_o
);
  localparam int CW = $clog2(READY_DLY + 1);

  logic [CW-1:0] cnt_q;
  logic          ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (!ready_q) begin
      if (cnt_q == CW'(READY_DLY - 1)) ready_q <= 1'b1;
      else                            cnt_q   <= cnt_q + 1'b1;
    end
  end

  // drop in the same cycle enable falls
  assign ready_o = ready_q & en_i;
endmodule

// File: rtl/sriov_rd_mux.sv
module sriov_rd_mux
  import sriov_cap_pkg::*;
#(
  parameter logic [11:0] NEXT_PTR    = 12'h000,
  parameter logic [3:0]  CAP_VER     = 4'h1,
  parameter logic [15:0] TOTAL_VFS   = 16'd64,
  parameter logic [15:0] INITIAL_VFS = 16'd0,
  parameter logic [15:0] FIRST_OFS   = 16'd1,
  parameter logic [15:0] VF_STRIDE   = 16'd1,
  parameter logic [15:0] VF_DEVID    = 16'hA5C3,
  parameter logic [31:0] SUP_PAGES   = 32'h0000_0553,
  parameter bit          MIG_CAP     = 1'b0,
  parameter logic [10:0] MIG_MSG     = 11'h02A
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  logic        hit_i,
  input  logic [3:0]  idx_i,
  input  ctrl_t       ctrl_i,
  input  logic [15:0] num_vfs_i,
  input  logic [31:0] sys_page_i,
  output logic [31:0] rdata_o
);
  logic [31:0] val, rdata_q;

  always_comb begin
    unique case (idx_i)
      W_HDR:   val = {NEXT_PTR, CAP_VER, CAP_ID};
      W_CAP:   val = {MIG_MSG, 20'h0, MIG_CAP};
      W_CTRL:  val = {27'h0, ctrl_i};
      W_VFLM:  val = {TOTAL_VFS, INITIAL_VFS};
      W_NUM:   val = {num_vfs_i, 16'h0};
      W_RID:   val = {VF_STRIDE, FIRST_OFS};
      W_DEV:   val = {VF_DEVID, 16'h0};
      W_SUP:   val = SUP_PAGES;
      W_PAGE:  val = sys_page_i;
      default: val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= hit_i ? val : '0;
  end

  assign rdata_o = rdata_q;

  assert_hdr_id_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit_i && idx_i == W_HDR) |=> rdata_o[15:0] == CAP_ID);
endmodule

// File: rtl/sriov_cap_regs.sv
module sriov_cap_regs
  import sriov_cap_pkg::*;
#(
  parameter logic [11:0] CAP_BASE    = 12'h100,
  parameter logic [11:0] NEXT_PTR    = 12'h000,
  parameter logic [3:0]  CAP_VER     = 4'h1,
  parameter logic [15:0] TOTAL_VFS   = 16'd64,
  parameter logic [15:0] INITIAL_VFS = 16'd0,
  parameter logic [15:0] FIRST_OFS   = 16'd1,
  parameter logic [15:0] VF_STRIDE   = 16'd1,
  parameter logic [15:0] VF_DEVID    = 16'hA5C3,
  parameter logic [31:0] SUP_PAGES   = 32'h0000_0553,
  parameter bit          MIG_CAP     = 1'b0,
  parameter logic [10:0] MIG_MSG     = 11'h02A,
  parameter int          READY_DLY   = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [9:0]  addr_i,
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [31:0] rdata_o,
  output logic        vf_en_o,
  output logic        mig_en_o,
  output logic        mig_int_en_o,
  output logic        vf_mse_o,
  output logic        ari_hier_o,
  output logic [15:0] num_vfs_o,
  output logic [15:0] first_ofs_o,
  output logic [15:0] stride_o,
  output logic [31:0] sys_page_o,
  output logic        vf_ready_o
);
  localparam logic [9:0] BASE_W = CAP_BASE[11:2];

  logic [9:0] woff;
  logic       hit;
  ctrl_t      ctrl;

  assign woff = addr_i - BASE_W;
  assign hit  = (addr_i >= BASE_W) && (woff <= {6'h0, W_PAGE});

  sriov_ctrl_regs #(
    .TOTAL_VFS(TOTAL_VFS), .SUP_PAGES(SUP_PAGES), .MIG_CAP(MIG_CAP)
  ) u_regs (
    .clk_i, .rst_ni,
    .wr_i      (wr_i & hit),
    .idx_i     (woff[3:0]),
    .be_i, .wdata_i,
    .ctrl_o    (ctrl),
    .num_vfs_o (num_vfs_o),
    .sys_page_o(sys_page_o)
  );

  sriov_rd_mux #(
    .NEXT_PTR(NEXT_PTR), .CAP_VER(CAP_VER), .TOTAL_VFS(TOTAL_VFS),
    .INITIAL_VFS(INITIAL_VFS), .FIRST_OFS(FIRST_OFS), .VF_STRIDE(VF_STRIDE),
    .VF_DEVID(VF_DEVID), .SUP_PAGES(SUP_PAGES), .MIG_CAP(MIG_CAP), .MIG_MSG(MIG_MSG)
  ) u_rd (
    .clk_i, .rst_ni, .rd_i,
    .hit_i     (hit),
    .idx_i     (woff[3:0]),
    .ctrl_i    (ctrl),
    .num_vfs_i (num_vfs_o),
    .sys_page_i(sys_page_o),
    .rdata_o   (rdata_o)
  );

  sriov_ready_timer #(.READY_DLY(READY_DLY)) u_tmr (
    .clk_i, .rst_ni,
    .en_i   (ctrl.vf_en),
    .ready_o(vf_ready_o)
  );

  assign vf_en_o      = ctrl.vf_en;
  assign mig_en_o     = ctrl.mig_en;
  assign mig_int_en_o = ctrl.mig_int_en;
  assign vf_mse_o     = ctrl.mse;
  assign ari_hier_o   = ctrl.ari;
  assign first_ofs_o  = FIRST_OFS;
  assign stride_o     = VF_STRIDE;

  assert_ready_after_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vf_ready_o) |-> $past(vf_en_o));
endmodule

// File: tb/sriov_cap_regs_test.sv
module sriov_cap_regs_test;
  localparam int DLY = 16;
  localparam logic [15:0] TOT = 16'd64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic        wr = 0, rd = 0;
  logic [31:0] rdata;
  logic        vf_en, mig_en, mig_int_en, vf_mse, ari;
  logic [15:0] num_vfs, first_ofs, stride;
  logic [31:0] sys_page;
  logic        vf_ready;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  sriov_cap_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .vf_en_o(vf_en), .mig_en_o(mig_en),
    .mig_int_en_o(mig_int_en), .vf_mse_o(vf_mse), .ari_hier_o(ari),
    .num_vfs_o(num_vfs), .first_ofs_o(first_ofs), .stride_o(stride),
    .sys_page_o(sys_page), .vf_ready_o(vf_ready)
  );

  function automatic logic [9:0] dw(input logic [11:0] off);
    logic [11:0] a;
    a = 12'h100 + off;
    return a[11:2];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] off, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    addr = dw(off); wdata = d; be = b; wr = 1;
    @(negedge clk);
    wr = 0; be = '0;
  endtask

  task automatic rd_reg(input logic [11:0] off, output logic [31:0] d);
    @(negedge clk);
    addr = dw(off); rd = 1;
    @(negedge clk);
    rd = 0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R11 ready", {31'h0, vf_ready}, 0);
    rd_reg(12'h008, d); chk("R11 ctrl", d, 0);
    rd_reg(12'h010, d); chk("R11 numvfs", d, 0);
    rd_reg(12'h020, d); chk("R11 page", d, 32'h1);
    chk("R11 page port", sys_page, 32'h1);
  endtask

  task automatic t_readonly;
    logic [31:0] d;
    rd_reg(12'h000, d); chk("R1 header", d, 32'h0001_0010);
    rd_reg(12'h024, d); chk("R1 unmapped above", d, 0);
    @(negedge clk); addr = 10'h03F; rd = 1; @(negedge clk); rd = 0;
    chk("R1 unmapped below", rdata, 0);
    rd_reg(12'h004, d); chk("R2 cap", d, {11'h02A, 21'h0});
    rd_reg(12'h00C, d); chk("R2 vf limits", d, {TOT, 16'd0});
    rd_reg(12'h014, d); chk("R2 rid", d, 32'h0001_0001);
    rd_reg(12'h018, d); chk("R2 devid", d, 32'hA5C3_0000);
    rd_reg(12'h01C, d); chk("R2 sup", d, 32'h553);
    wr_reg(12'h00C, 32'hFFFF_FFFF, 4'hF);
    wr_reg(12'h01C, 32'h0, 4'hF);
    rd_reg(12'h00C, d); chk("R2 vf limits after write", d, {TOT, 16'd0});
    rd_reg(12'h01C, d); chk("R2 sup after write", d, 32'h553);
    chk("R2 offset port", {first_ofs, stride}, 32'h0001_0001);
  endtask

  task automatic t_control;
    logic [31:0] d;
    wr_reg(12'h008, 32'hFFFF_FF1E, 4'hF);
    rd_reg(12'h008, d); chk("R3 ctrl readback", d, 32'h1C);
    chk("R7 mig blocked", {31'h0, mig_en}, 0);
    chk("R3 ports", {27'h0, ari, vf_mse, mig_int_en, mig_en, vf_en}, 32'h1C);
    wr_reg(12'h008, 32'h0, 4'hE);
    rd_reg(12'h008, d); chk("R8 ctrl be0 clear", d, 32'h1C);
    wr_reg(12'h008, 32'h0, 4'h1);
    rd_reg(12'h008, d); chk("R3 ctrl cleared", d, 0);
  endtask

  task automatic t_numvfs;
    logic [31:0] d;
    wr_reg(12'h010, 32'h0004_0000, 4'hF);
    chk("R5 num set", {16'h0, num_vfs}, 4);
    wr_reg(12'h008, 32'h1, 4'h1);
    wr_reg(12'h010, 32'h0008_0000, 4'hF);
    rd_reg(12'h010, d); chk("R4 locked", d, 32'h0004_0000);
    wr_reg(12'h008, 32'h0, 4'h1);
    wr_reg(12'h010, 32'h0008_0000, 4'hF);
    chk("R4 unlocked", {16'h0, num_vfs}, 8);
    wr_reg(12'h010, {TOT + 16'd1, 16'h0}, 4'hF);
    chk("R5 above total", {16'h0, num_vfs}, 8);
    wr_reg(12'h010, {TOT, 16'h0}, 4'hF);
    chk("R5 at total", {16'h0, num_vfs}, {16'h0, TOT});
    wr_reg(12'h010, 32'h0305_0000, 4'h4);
    chk("R8 numvfs low byte", {16'h0, num_vfs}, 32'h0005);
  endtask

  task automatic t_page;
    wr_reg(12'h020, 32'h2, 4'hF);   chk("R6 8K accepted", sys_page, 32'h2);
    wr_reg(12'h020, 32'h4, 4'hF);   chk("R6 unsupported", sys_page, 32'h2);
    wr_reg(12'h020, 32'h3, 4'hF);   chk("R6 two bits", sys_page, 32'h2);
    wr_reg(12'h020, 32'h0, 4'hF);   chk("R6 zero", sys_page, 32'h2);
    wr_reg(12'h020, 32'h100, 4'hF); chk("R6 1M accepted", sys_page, 32'h100);
    wr_reg(12'h020, 32'h1, 4'h2);   chk("R8 page masked", sys_page, 32'h100);
    wr_reg(12'h020, 32'h0000_0010, 4'h1);
    chk("R8 page merged two bits", sys_page, 32'h100);
  endtask

  task automatic t_ready;
    wr_reg(12'h008, 32'h1, 4'h1);
    for (int i = 1; i < DLY; i++) begin
      @(negedge clk);
      if (i == 1 || i == DLY - 1) chk("R9 not yet", {31'h0, vf_ready}, 0);
    end
    @(negedge clk);
    chk("R9 ready", {31'h0, vf_ready}, 1);
    wr_reg(12'h008, 32'h0, 4'h1);
    chk("R10 drop", {31'h0, vf_ready}, 0);
    wr_reg(12'h008, 32'h1, 4'h1);
    repeat (DLY - 1) @(negedge clk);
    chk("R10 restart not yet", {31'h0, vf_ready}, 0);
    @(negedge clk);
    chk("R10 restart ready", {31'h0, vf_ready}, 1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_readonly();
        t_control();
        t_numvfs();
        t_page();
        t_ready();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule